// File: doc/BRIEF.md
# Run-Length IR Pulse Transmitter

This block plays out a remote-control waveform that software has prepared as a list of run-length coded bytes. Each byte says whether the next interval is a mark (emitter driven with a carrier) or a space (emitter quiet) and how long that interval lasts in steps of one time-base tick (10 µs at the default clock). The bytes sit in a small transmit queue loaded through a four-address write port. A sequencer takes them one at a time and times each interval with a prescaler and a tick counter. During a mark, the one emitter output chosen by software is gated by a pulse train whose frequency comes from a 5-bit code.

Software keeps the queue topped up with the help of two level flags: one says few entries remain and one says the queue is empty. When software reaches the final byte of a frame, it first arms an end-of-frame marker. The byte written next carries that marker, and the transmitter stops cleanly after playing it. If the queue runs dry before a marked byte has been played, the transmitter stops and raises a sticky underrun flag. An invert control flips the polarity of every emitter output.

Top module: `ir_burst_tx`

## Requirements
- R1: A data byte with bit 7 = 0 is a mark and with bit 7 = 1 is a space. Bits 6:0 hold n, and the interval lasts (n+1) ticks, where one tick is CLK_KHZ/100 clock cycles (10 µs).
- R2: The queue holds 16 bytes. A data write (address 0) that arrives while the queue is full is discarded, and the queued contents are left unchanged.
- R3: tx_low is 1 while the queue holds 3 or fewer bytes, and tx_empty is 1 while it holds none.
- R4: Writing address 1 with bit 0 = 1 arms an end-of-frame marker, and the next accepted data byte carries it. When that byte has played, tx_busy drops and tx_underrun stays 0.
- R5: If an unmarked interval ends while the queue is empty, tx_busy drops and tx_underrun becomes 1. tx_underrun stays 1 until address 1 is written with bit 1 = 1.
- R6: The carrier code is in address 2, bits 4:0. Codes 0 to 2 select (58+code) kHz, and codes 3 to 31 select (code+27) kHz. The carrier period is round(CLK_KHZ/kHz) clock cycles.
- R7: In each carrier period the pulse is high for the first CLK_KHZ*7/1000 cycles (7 µs). Every mark starts at the beginning of a carrier period.
- R8: After reset the carrier code is 9 (36 kHz), emitter 0 is selected, invert is off, the queue is empty, tx_busy is 0, tx_underrun is 0 and all outputs are 0.
- R9: Address 3, bits 1:0 select one emitter. Only that output carries the gated carrier during a mark. Every other output holds the inactive level at all times.
- R10: Address 3, bit 2 inverts all emitter outputs. The inactive level then becomes 1.
- R11: Consecutive queued bytes play back to back, with no idle cycle between intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (CLK_KHZ) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 control, 2 carrier code, 3 emitter config |
| wr_data | input | 8 | Write data |
| ir_out | output | 4 | Emitter outputs |
| tx_low | output | 1 | Queue holds 3 or fewer bytes |
| tx_empty | output | 1 | Queue is empty |
| tx_underrun | output | 1 | Sticky underrun flag |
| tx_busy | output | 1 | An interval is being played |

## Verification
The hardest states to reach from the ports are a completely full queue and an occupancy of exactly three or four entries, because the sequencer starts draining as soon as the first byte arrives. The stimulus therefore writes a long mark first. While that mark plays, it adds bytes one per cycle, checks the level flags at three and at four entries, fills the queue to sixteen, and then writes three more bytes that must be dropped. A scoreboard then confirms that exactly the seventeen accepted intervals appear on the emitter, cycle by cycle, and that the frame ends after the marked byte.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    localparam int EMIT_N   = 4;
    localparam int SEL_W    = $clog2(EMIT_N);
    localparam int CODE_W   = 5;
    localparam int CODE_N   = 1 << CODE_W;
    localparam int DUR_W    = 7;
    localparam logic [CODE_W-1:0] CODE_RESET = 5'd9;   // 36 kHz

    // one queued interval
    typedef struct packed {
        logic             last;   // end-of-frame marker
        logic             space;  // 1 = space, 0 = mark
        logic [DUR_W-1:0] dur;    // ticks minus one
    } tx_entry_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              inv;
        logic [CODE_W-1:0] code;
    } tx_cfg_t;

    typedef enum logic {SQ_IDLE, SQ_PLAY} sq_state_t;

    function automatic int carrier_khz(input int code);
        return (code < 3) ? 58 + code : code + 27;
    endfunction

    function automatic int carrier_period(input int clk_khz, input int code);
        int f;
        f = carrier_khz(code);
        return (clk_khz + f / 2) / f;
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  tx_entry_t din,
    input  logic      pop,
    output tx_entry_t head,
    output logic      full,
    output logic      empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    tx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic            do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
    import ir_tx_pkg::*;
#(
    parameter int CLK_KHZ  = 24000,
    parameter int PULSE_US = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              restart,
    output logic              carrier_on
);
    localparam int CNT_W  = $clog2(CLK_KHZ / 30 + 2);
    localparam int HIGH_C = CLK_KHZ * PULSE_US / 1000;

    logic [CNT_W-1:0] period_lut [CODE_N];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;

    for (genvar c = 0; c < CODE_N; c++) begin : g_lut
        assign period_lut[c] = CNT_W'(carrier_period(CLK_KHZ, c));
    end

    assign period     = period_lut[code];
    assign carrier_on = (cnt < CNT_W'(HIGH_C));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt >= period - 1'b1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R7
    mark_phase_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> carrier_on);

endmodule

// File: rtl/ir_tx_sequencer.sv
module ir_tx_sequencer
    import ir_tx_pkg::*;
#(
    parameter int TICK_CYC = 240
) (
    input  logic      clk,
    input  logic      rst,
    input  tx_entry_t head,
    input  logic      q_empty,
    input  logic      ur_clr,
    output logic      pop,
    output logic      busy,
    output logic      mark,
    output logic      underrun
);
    localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    sq_state_t        state;
    tx_entry_t        cur;
    logic [PW-1:0]    pre;
    logic [DUR_W-1:0] left;
    logic             tick_end, sym_end;

    assign busy     = (state == SQ_PLAY);
    assign mark     = busy && !cur.space;
    assign tick_end = busy && (pre == PW'(TICK_CYC - 1));
    assign sym_end  = tick_end && (left == '0);
    assign pop      = !q_empty && ((state == SQ_IDLE) || (sym_end && !cur.last));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cur      <= '0;
            pre      <= '0;
            left     <= '0;
            underrun <= 1'b0;
        end else begin
            if (ur_clr)
                underrun <= 1'b0;
            if (pop) begin
                cur   <= head;
                left  <= head.dur;
                pre   <= '0;
                state <= SQ_PLAY;
            end else if (sym_end) begin
                state <= SQ_IDLE;
                if (!cur.last)
                    underrun <= 1'b1;
            end else if (tick_end) begin
                pre  <= '0;
                left <= left - 1'b1;
            end else if (busy) begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R5
    underrun_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> !busy);

    // R4
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_end && cur.last) |=> (!busy && !$rose(underrun)));

endmodule

// File: rtl/ir_burst_tx.sv
module ir_burst_tx
    import ir_tx_pkg::*;
#(
    parameter int CLK_KHZ  = 24000,
    parameter int PULSE_US = 7,
    parameter int DEPTH    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [EMIT_N-1:0] ir_out,
    output logic              tx_low,
    output logic              tx_empty,
    output logic              tx_underrun,
    output logic              tx_busy
);
    localparam int TICK_CYC = CLK_KHZ / 100;
    localparam int CW       = $clog2(DEPTH + 1);
    localparam int LOW_MARK = 3;

    tx_cfg_t   cfg;
    tx_entry_t din, head;
    logic      eot_armed, push, pop, full, empty, ur_clr, mark, car_on;
    logic [CW-1:0] count;

    assign push   = wr_en && (wr_addr == 2'd0);
    assign ur_clr = wr_en && (wr_addr == 2'd1) && wr_data[1];
    assign din    = '{last: eot_armed, space: wr_data[7], dur: wr_data[DUR_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '{sel: '0, inv: 1'b0, code: CODE_RESET};
            eot_armed <= 1'b0;
        end else begin
            if (wr_en && wr_addr == 2'd1 && wr_data[0])
                eot_armed <= 1'b1;
            else if (push && !full)
                eot_armed <= 1'b0;
            if (wr_en && wr_addr == 2'd2)
                cfg.code <= wr_data[CODE_W-1:0];
            if (wr_en && wr_addr == 2'd3) begin
                cfg.sel <= wr_data[SEL_W-1:0];
                cfg.inv <= wr_data[SEL_W];
            end
        end
    end

    ir_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk, .rst, .push, .din, .pop, .head, .full, .empty, .count
    );

    ir_tx_sequencer #(.TICK_CYC(TICK_CYC)) u_seq (
        .clk, .rst, .head, .q_empty(empty), .ur_clr, .pop,
        .busy(tx_busy), .mark, .underrun(tx_underrun)
    );

    ir_tx_carrier #(.CLK_KHZ(CLK_KHZ), .PULSE_US(PULSE_US)) u_car (
        .clk, .rst, .code(cfg.code), .restart(pop), .carrier_on(car_on)
    );

    for (genvar i = 0; i < EMIT_N; i++) begin : g_emit
        assign ir_out[i] = ((cfg.sel == SEL_W'(i)) && mark && car_on) ^ cfg.inv;
    end

    assign tx_empty = empty;
    assign tx_low   = (count <= CW'(LOW_MARK));

    // R9
    one_emitter_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ir_out ^ {EMIT_N{cfg.inv}}) <= 1);

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> (ir_out == {EMIT_N{cfg.inv}}));

    // R3
    empty_low_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_low);

endmodule

// File: tb/ir_burst_tx_tb.sv
module ir_burst_tx_tb;
    localparam int CLK_KHZ = 2400;
    localparam int TICK    = CLK_KHZ / 100;
    localparam int PULSE   = CLK_KHZ * 7 / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] ir_out;
    logic       tx_low, tx_empty, tx_underrun, tx_busy;

    always #2 clk = ~clk;

    ir_burst_tx #(.CLK_KHZ(CLK_KHZ)) u_dut (
        .clk, .rst, .wr_en, .wr_addr, .wr_data,
        .ir_out, .tx_low, .tx_empty, .tx_underrun, .tx_busy
    );

    typedef struct {
        bit space;
        int cycles;
        bit last;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int g_sel = 0;
    int g_inv = 0;
    int g_code = 9;
    bit done = 0;

    function automatic int period_of(int code);
        int f;
        f = (code < 3) ? 58 + code : code + 27;
        return (CLK_KHZ + f / 2) / f;
    endfunction

    function automatic logic [3:0] exp_out(bit space, int k);
        logic [3:0] v;
        for (int i = 0; i < 4; i++)
            v[i] = ((i == g_sel) && !space && ((k % period_of(g_code)) < PULSE)) ^ g_inv[0];
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: queue the expected interval, then write the byte
    task automatic send(bit space, int n, bit last_exp, bit eot);
        exp_t e;
        e.space = space; e.cycles = (n + 1) * TICK; e.last = last_exp;
        q.push_back(e);
        if (eot) wr(2'd1, 8'h01);
        wr(2'd0, {space, 7'(n)});
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || tx_busy);
        repeat (3) @(negedge clk);
    endtask

    // monitor: compare each interval cycle by cycle against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (tx_busy) begin
                exp_t it;
                do begin
                    int bad = 0;
                    logic [3:0] first_bad_act = '0, first_bad_exp = '0;
                    if (q.size() == 0) begin
                        check(0, "R1 unexpected interval", 1, 0);
                        it.space = 1; it.cycles = 1; it.last = 1;
                    end else
                        it = q.pop_front();
                    for (int k = 0; k < it.cycles; k++) begin
                        if (ir_out !== exp_out(it.space, k)) begin
                            if (bad == 0) begin
                                first_bad_act = ir_out;
                                first_bad_exp = exp_out(it.space, k);
                            end
                            bad++;
                        end
                        @(negedge clk);
                    end
                    // R1 R6 R7 R9 R10 R11: waveform of one interval
                    check(bad == 0, "R1/R6/R7/R9/R10/R11 waveform",
                          int'(first_bad_act), int'(first_bad_exp));
                end while (!it.last);
                // R4 R5: transmitter stops after the frame's final interval
                check(!tx_busy, "R4/R5 busy after frame", int'(tx_busy), 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        check(ir_out == 4'h0, "R8 ir_out", int'(ir_out), 0);
        check(tx_empty && tx_low, "R8 empty/low", int'({tx_empty, tx_low}), 3);
        check(!tx_busy && !tx_underrun, "R8 busy/underrun", int'({tx_busy, tx_underrun}), 0);

        // frame A: default 36 kHz carrier on emitter 0, back to back (R11)
        send(0, 2, 0, 0);
        send(1, 0, 0, 0);
        send(0, 5, 1, 1);
        wait_idle();
        check(!tx_underrun, "R4 no underrun after marked byte", int'(tx_underrun), 0);

        // frame B: emitter 2, 58 kHz; occupancy and full-queue drop
        g_sel = 2; g_code = 0;
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h00);
        send(0, 10, 0, 0);           // long first mark holds the queue
        send(1, 0, 0, 0);
        send(0, 1, 0, 0);
        send(1, 2, 0, 0);
        check(tx_low && !tx_empty, "R3 three entries", int'({tx_low, tx_empty}), 2);
        send(0, 0, 0, 0);
        check(!tx_low && !tx_empty, "R3 four entries", int'({tx_low, tx_empty}), 0);
        for (int i = 0; i < 11; i++) send(i[0], 0, 0, 0);
        send(0, 3, 1, 1);            // 16th queued byte ends the frame
        check(!tx_low, "R2 full queue", int'(tx_low), 0);
        for (int i = 0; i < 3; i++) wr(2'd0, 8'h32);  // R2: dropped
        wait_idle();
        check(tx_empty && tx_low, "R3 drained", int'({tx_empty, tx_low}), 3);

        // frame C: underrun on emitter 1, inverted, 57 kHz
        g_sel = 1; g_inv = 1; g_code = 30;
        wr(2'd3, 8'h05);
        wr(2'd2, 8'd30);
        @(negedge clk);
        check(ir_out == 4'hF, "R10 inverted idle", int'(ir_out), 15);
        send(0, 1, 1, 0);
        wait_idle();
        check(tx_underrun, "R5 underrun set", int'(tx_underrun), 1);
        repeat (20) @(negedge clk);
        check(tx_underrun, "R5 underrun sticky", int'(tx_underrun), 1);
        wr(2'd1, 8'h02);
        check(!tx_underrun, "R5 underrun cleared", int'(tx_underrun), 0);

        // frame D: 30 kHz then 60 kHz on emitter 3 (R6 mapping ends)
        g_sel = 3; g_inv = 0; g_code = 3;
        wr(2'd3, 8'h03);
        wr(2'd2, 8'd3);
        send(0, 7, 1, 1);
        wait_idle();
        g_code = 2;
        wr(2'd2, 8'd2);
        send(0, 7, 0, 0);
        send(1, 1, 0, 0);
        send(0, 4, 1, 1);
        wait_idle();
        check(!tx_underrun, "R4 clean end", int'(tx_underrun), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule